// File: doc/BRIEF.md
# Core Mailbox and Signal Notification Unit

This unit passes messages between one accelerator core and the rest of the system. The core sees unidirectional 32-bit channels with blocking semantics: it offers a write, or asks for a read, and the transfer completes only once the selected channel can take or supply a word. Reads that find nothing to return, and writes into a full queue, simply wait.

On the host side a small register window with read and write strobes reaches the same state. Two outbound queues carry words from the core to the host. Words placed in the second one raise a host interrupt, so the host does not have to poll. One inbound queue carries words from the host to the core. Two notification words collect bits from the host by OR-merging. The core can only read them, and a core read clears the word. The core learns of a notification by polling, by a blocking read, or through a per-word enabled core interrupt.

Top module: `mbox_sig_unit`

## Requirements
- R1: After reset all queues are empty, both notification words are zero, `host_irq` and `core_sig_irq` are low and the status word reads 0.
- R2: A core write on channel 0 (plain) or 1 (interrupting) queues a word that the host reads at address 0 or 1 respectively, in arrival order. A host read of an empty outbound queue returns 0 and changes nothing.
- R3: Each outbound queue holds one word. While it is full, `cw_ready` is low for that channel and the core write stalls until the host reads the word.
- R4: `host_irq` is high from the clock edge that stores a word in the interrupting queue until the edge on which a host read of address 1 empties it. Writes to channel 0 never raise it.
- R5: A host write to address 2 appends to the four-entry inbound queue. A write while it is full is dropped.
- R6: A core read on channel 0 stalls while the inbound queue is empty. Otherwise it returns the oldest word and removes it.
- R7: A host write to address 3 (notification 0) or 4 (notification 1) ORs the data into that word. A host read returns the word without clearing it.
- R8: A core read on channel 1 (notification 0) or 2 (notification 1) stalls while the word is zero. Otherwise it returns the word and clears it. Bits that the host writes in the same cycle remain set.
- R9: Host address 5 returns status: bits 7:0 hold the inbound count, bits 15:8 the count of outbound queue 0 and bits 23:16 the count of outbound queue 1.
- R10: `core_sig_irq` goes high one cycle after any notification word with its `sig_irq_en` bit set is non-zero, and low one cycle after none is.
- R11: `h_rdata` is registered. It holds the result one cycle after `h_rd`, and unmapped addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cw_valid | input | 1 | Core offers a channel write |
| cw_chan | input | 1 | Write channel: 0 plain outbound, 1 interrupting outbound |
| cw_data | input | 32 | Core write word |
| cw_ready | output | 1 | Selected write channel can accept |
| cr_valid | input | 1 | Core requests a channel read |
| cr_chan | input | 2 | Read channel: 0 inbound, 1 notification 0, 2 notification 1 |
| cr_data | output | 32 | Word returned to the core |
| cr_ready | output | 1 | Selected read channel has data |
| sig_irq_en | input | 2 | Per-notification core interrupt enable |
| core_sig_irq | output | 1 | Core notification interrupt |
| h_wr | input | 1 | Host write strobe |
| h_rd | input | 1 | Host read strobe |
| h_addr | input | 4 | Host register address |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data, registered |
| host_irq | output | 1 | Host interrupt from outbound queue 1 |

## Verification
The bench builds the unit with its defaults: an inbound depth of four, single-entry outbound queues and 32-bit words. These values let it fill every queue within a few cycles. That brings the full-queue stall, the dropped fifth inbound write and the interrupt release on the emptying read all within reach. The small notification width is still 32 bits, so a table of OR patterns can exercise both the low and high bits before the clearing read. A same-cycle host write and core read is also reached directly.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int NSIG = 2;
  // host register addresses
  localparam int HA_OUT_PLAIN = 0;
  localparam int HA_OUT_IRQ   = 1;
  localparam int HA_INBOX     = 2;
  localparam int HA_SIG0      = 3;
  localparam int HA_STATUS    = 5;
  // core read channel codes
  localparam logic [1:0] RCH_INBOX = 2'd0;
  localparam logic [1:0] RCH_SIG0  = 2'd1;
endpackage

// File: rtl/mbox_fifo.sv
module mbox_fifo #(
  parameter int W = 32,
  parameter int DEPTH = 4,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [W-1:0]     push_data,
  input  logic             pop,
  output logic [W-1:0]     head,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [2**PW];
  logic [PW-1:0] wp, rp;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp <= '0;
      rp <= '0;
      count <= '0;
    end else begin
      if (push) wp <= nxt(wp);
      if (pop)  rp <= nxt(rp);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign head  = mem[rp];
  assign full  = (count == CNT_W'(DEPTH));
  assign empty = (count == '0);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst) push |-> !full); // R3
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst) pop |-> !empty); // R6
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst) count <= CNT_W'(DEPTH)); // R5
endmodule

// File: rtl/mbox_sig.sv
module mbox_sig #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         set_en,
  input  logic [W-1:0] set_bits,
  input  logic         clr,
  output logic [W-1:0] value
);
  always_ff @(posedge clk) begin
    if (rst)
      value <= '0;
    else if (set_en || clr)
      value <= (clr ? '0 : value) | (set_en ? set_bits : '0);
  end

  AST_SIG_CLEARED: assert property (@(posedge clk) disable iff (rst) (clr && !set_en) |=> value == '0); // R8
  AST_SIG_STICKY: assert property (@(posedge clk) disable iff (rst) !clr |=> (value & $past(value)) == $past(value)); // R7
endmodule

// File: rtl/mbox_sig_unit.sv
module mbox_sig_unit #(
  parameter int W = 32,
  parameter int IN_DEPTH = 4,
  parameter int OUT_DEPTH = 1,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cw_valid,
  input  logic              cw_chan,
  input  logic [W-1:0]      cw_data,
  output logic              cw_ready,
  input  logic              cr_valid,
  input  logic [1:0]        cr_chan,
  output logic [W-1:0]      cr_data,
  output logic              cr_ready,
  input  logic [1:0]        sig_irq_en,
  output logic              core_sig_irq,
  input  logic              h_wr,
  input  logic              h_rd,
  input  logic [ADDR_W-1:0] h_addr,
  input  logic [W-1:0]      h_wdata,
  output logic [W-1:0]      h_rdata,
  output logic              host_irq
);
  import mbox_pkg::*;

  localparam int IN_CW  = $clog2(IN_DEPTH + 1);
  localparam int OUT_CW = $clog2(OUT_DEPTH + 1);

  // outbound queues: index 0 plain, index 1 interrupting
  logic [W-1:0]      out_head [2];
  logic [OUT_CW-1:0] out_cnt  [2];
  logic [1:0]        out_full, out_empty, out_push, out_pop;

  for (genvar q = 0; q < 2; q++) begin : g_out
    assign out_push[q] = cw_valid && (cw_chan == 1'(q)) && !out_full[q];
    assign out_pop[q]  = h_rd && (h_addr == ADDR_W'(HA_OUT_PLAIN + q)) && !out_empty[q];
    mbox_fifo #(.W(W), .DEPTH(OUT_DEPTH), .CNT_W(OUT_CW)) u_out (
      .clk(clk), .rst(rst), .push(out_push[q]), .push_data(cw_data),
      .pop(out_pop[q]), .head(out_head[q]), .count(out_cnt[q]),
      .full(out_full[q]), .empty(out_empty[q])
    );
  end

  assign cw_ready = !out_full[cw_chan];

  // inbound queue
  logic [W-1:0]     in_head;
  logic [IN_CW-1:0] in_cnt;
  logic             in_full, in_empty, in_push, in_pop, cr_fire;

  assign in_push = h_wr && (h_addr == ADDR_W'(HA_INBOX)) && !in_full;
  assign cr_fire = cr_valid && cr_ready;
  assign in_pop  = cr_fire && (cr_chan == RCH_INBOX);

  mbox_fifo #(.W(W), .DEPTH(IN_DEPTH), .CNT_W(IN_CW)) u_in (
    .clk(clk), .rst(rst), .push(in_push), .push_data(h_wdata),
    .pop(in_pop), .head(in_head), .count(in_cnt),
    .full(in_full), .empty(in_empty)
  );

  // notification words
  logic [W-1:0]    sig_val [NSIG];
  logic [NSIG-1:0] sig_nz;

  for (genvar s = 0; s < NSIG; s++) begin : g_sig
    logic set_s, clr_s;
    assign set_s = h_wr && (h_addr == ADDR_W'(HA_SIG0 + s));
    assign clr_s = cr_fire && (cr_chan == (RCH_SIG0 + 2'(s)));
    mbox_sig #(.W(W)) u_sig (
      .clk(clk), .rst(rst), .set_en(set_s), .set_bits(h_wdata),
      .clr(clr_s), .value(sig_val[s])
    );
    assign sig_nz[s] = (sig_val[s] != '0);
  end

  // core read channel mux
  always_comb begin
    case (cr_chan)
      2'd0:    begin cr_ready = !in_empty; cr_data = in_head;    end
      2'd1:    begin cr_ready = sig_nz[0]; cr_data = sig_val[0]; end
      2'd2:    begin cr_ready = sig_nz[1]; cr_data = sig_val[1]; end
      default: begin cr_ready = 1'b0;      cr_data = '0;         end
    endcase
  end

  // host read data, registered
  logic [W-1:0] status;
  assign status = W'({8'(out_cnt[1]), 8'(out_cnt[0]), 8'(in_cnt)});

  always_ff @(posedge clk) begin
    if (rst)
      h_rdata <= '0;
    else if (h_rd) begin
      case (int'(h_addr))
        HA_OUT_PLAIN: h_rdata <= out_empty[0] ? '0 : out_head[0];
        HA_OUT_IRQ:   h_rdata <= out_empty[1] ? '0 : out_head[1];
        HA_SIG0:      h_rdata <= sig_val[0];
        HA_SIG0 + 1:  h_rdata <= sig_val[1];
        HA_STATUS:    h_rdata <= status;
        default:      h_rdata <= '0;
      endcase
    end
  end

  // interrupts
  always_ff @(posedge clk) begin
    if (rst) begin
      host_irq     <= 1'b0;
      core_sig_irq <= 1'b0;
    end else begin
      if (out_push[1])
        host_irq <= 1'b1;
      else if (out_pop[1] && out_cnt[1] == OUT_CW'(1))
        host_irq <= 1'b0;
      core_sig_irq <= |(sig_nz & sig_irq_en);
    end
  end

  AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (rst)
    (cw_valid && cw_ready && cw_chan) |=> host_irq); // R4
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (host_irq && !(h_rd && h_addr == ADDR_W'(HA_OUT_IRQ))) |=> host_irq); // R4
  AST_RD_NO_DATA: assert property (@(posedge clk) disable iff (rst)
    (h_rd && h_addr == ADDR_W'(HA_OUT_PLAIN) && !cw_valid && out_empty[0]) |=> h_rdata == '0); // R2
endmodule

// File: tb/test_mbox_sig_unit.sv
module test_mbox_sig_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic        cw_valid, cw_chan, cw_ready;
  logic [31:0] cw_data;
  logic        cr_valid, cr_ready;
  logic [1:0]  cr_chan;
  logic [31:0] cr_data;
  logic [1:0]  sig_irq_en;
  logic        core_sig_irq;
  logic        h_wr, h_rd;
  logic [3:0]  h_addr;
  logic [31:0] h_wdata, h_rdata;
  logic        host_irq;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  mbox_sig_unit i_mbox_sig_unit (
    .clk(clk), .rst(rst),
    .cw_valid(cw_valid), .cw_chan(cw_chan), .cw_data(cw_data), .cw_ready(cw_ready),
    .cr_valid(cr_valid), .cr_chan(cr_chan), .cr_data(cr_data), .cr_ready(cr_ready),
    .sig_irq_en(sig_irq_en), .core_sig_irq(core_sig_irq),
    .h_wr(h_wr), .h_rd(h_rd), .h_addr(h_addr), .h_wdata(h_wdata),
    .h_rdata(h_rdata), .host_irq(host_irq)
  );

  typedef struct packed { logic [31:0] wr; logic [31:0] exp; } sig_vec_t;
  localparam sig_vec_t SIG_TABLE [5] = '{
    '{32'h0000_0001, 32'h0000_0001},
    '{32'h0000_0010, 32'h0000_0011},
    '{32'h0000_0011, 32'h0000_0011},
    '{32'h8000_0000, 32'h8000_0011},
    '{32'h0000_00F0, 32'h8000_00F1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); h_wr = 1'b1; h_addr = a; h_wdata = d;
    @(negedge clk); h_wr = 1'b0;
  endtask

  task automatic host_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); h_rd = 1'b1; h_addr = a;
    @(negedge clk); h_rd = 1'b0; d = h_rdata;
  endtask

  task automatic core_write(input logic ch, input logic [31:0] d);
    @(negedge clk); cw_valid = 1'b1; cw_chan = ch; cw_data = d;
    #1;
    while (!cw_ready) begin @(negedge clk); #1; end
    @(negedge clk); cw_valid = 1'b0;
  endtask

  task automatic core_read(input logic [1:0] ch, output logic [31:0] d);
    @(negedge clk); cr_valid = 1'b1; cr_chan = ch;
    #1;
    while (!cr_ready) begin @(negedge clk); #1; end
    d = cr_data;
    @(negedge clk); cr_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    rst = 1'b1; cw_valid = 0; cw_chan = 0; cw_data = 0; cr_valid = 0; cr_chan = 0;
    sig_irq_en = 0; h_wr = 0; h_rd = 0; h_addr = 0; h_wdata = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    @(negedge clk);
    check("R1 host_irq", 32'(host_irq), 0);
    check("R1 core_sig_irq", 32'(core_sig_irq), 0);
    check("R1 cw_ready", 32'(cw_ready), 1);
    check("R6 empty inbound stalls", 32'(cr_ready), 0);
    host_read(4'd5, d); check("R1 status", d, 0);

    // R2/R3/R4 plain outbound
    core_write(1'b0, 32'hA5A5_0001);
    check("R4 plain write no irq", 32'(host_irq), 0);
    cw_chan = 1'b0; #1;
    check("R3 plain full stalls", 32'(cw_ready), 0);
    host_read(4'd5, d); check("R9 status plain", d, 32'h0000_0100);
    host_read(4'd0, d); check("R2 plain read", d, 32'hA5A5_0001);
    host_read(4'd0, d); check("R2 empty read zero", d, 0);

    // R4 interrupting outbound
    core_write(1'b1, 32'h0000_B0B0);
    check("R4 irq raised", 32'(host_irq), 1);
    @(negedge clk); cw_valid = 1'b1; cw_chan = 1'b1; cw_data = 32'hDEAD; #1;
    check("R3 irq queue full stalls", 32'(cw_ready), 0);
    @(negedge clk); cw_valid = 1'b0;
    host_read(4'd5, d); check("R9 status irq", d, 32'h0001_0000);
    check("R4 irq held", 32'(host_irq), 1);
    host_read(4'd1, d); check("R2 irq queue read", d, 32'h0000_B0B0);
    check("R4 irq released", 32'(host_irq), 0);

    // R5/R6 inbound
    for (int i = 0; i < 5; i++) host_write(4'd2, 32'h100 + 32'(i));
    host_read(4'd5, d); check("R9 status inbound full", d, 32'h0000_0004);
    for (int i = 0; i < 4; i++) begin
      core_read(2'd0, d); check("R5 inbound order", d, 32'h100 + 32'(i));
    end
    cr_chan = 2'd0; #1;
    check("R6 drained stalls", 32'(cr_ready), 0);

    // R7 notification OR table
    for (int i = 0; i < 5; i++) begin
      host_write(4'd3, SIG_TABLE[i].wr);
      host_read(4'd3, d); check("R7 OR merge", d, SIG_TABLE[i].exp);
    end
    @(negedge clk);
    check("R10 disabled irq low", 32'(core_sig_irq), 0);
    sig_irq_en = 2'b01;
    @(negedge clk);
    check("R10 enabled irq high", 32'(core_sig_irq), 1);
    core_read(2'd1, d); check("R8 core read value", d, 32'h8000_00F1);
    cr_chan = 2'd1; #1;
    check("R8 cleared stalls", 32'(cr_ready), 0);
    @(negedge clk);
    check("R10 irq drops", 32'(core_sig_irq), 0);
    host_read(4'd3, d); check("R8 cleared value", d, 0);

    // R8 same-cycle host set and core clear on notification 1
    host_write(4'd4, 32'h3);
    @(negedge clk);
    cr_valid = 1'b1; cr_chan = 2'd2; h_wr = 1'b1; h_addr = 4'd4; h_wdata = 32'h40;
    #1; check("R8 read during set", cr_data, 32'h3);
    @(negedge clk); cr_valid = 1'b0; h_wr = 1'b0;
    host_read(4'd4, d); check("R8 new bits survive", d, 32'h40);

    // R11 unmapped
    host_read(4'd7, d); check("R11 unmapped zero", d, 0);

    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule